// File: doc/BRIEF.md
# Serial Peripheral Slave Front-End with Pause

This block is the bit-level front-end of a serial peripheral slave. It sits between the four pins of the bus (serial clock, active-low select, data in, active-low pause) and a command layer. All four pins are sampled in the system clock domain through synchronisers, and clock edges are found by comparing successive synchronised samples. Received bits are assembled into bytes. Outgoing bytes are shifted onto the data-out pin, which has its own output enable so that it can float.

Toward the command layer the block offers a received-byte strobe, a transaction-start strobe and a transaction-end strobe. The end strobe carries the count of whole bytes and a flag that marks a trailing fragment, so that a downstream commit rule can accept or reject the transaction. Both data paths are paced by the bus master, so neither can stall. `rx_valid_o` is a one-cycle strobe that the consumer must take in that cycle. On the transmit side, `tx_req_o` works as a ready strobe: the command layer must present valid `tx_data_i` in every cycle in which `tx_req_o` is high, and that byte is consumed in that cycle.

A pause is entered when the pause pin falls while the serial clock is low, and it is left when the pin rises while the clock is low. While the block is paused, its bit position is frozen and data-out floats, and the transfer then continues from the same bit.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data-in is sampled on each qualified rising serial-clock edge, most significant bit first. After every eighth such sample, `rx_valid_o` pulses for exactly one cycle and `rx_data_o` holds the assembled byte, with the first received bit in bit 7.
- R2: Data-out shows bit 7 of the byte loaded at transaction start before the first rising edge. It moves to the next lower bit on each falling edge that follows a rising edge. On the falling edge that follows the eighth rising edge, the next byte is loaded. A load happens exactly in the cycles where `tx_req_o` is high, and `tx_req_o` is never high in two consecutive cycles.
- R3: A falling edge that arrives before any rising edge of a transaction does not move data-out. This covers a clock that idles high when select falls.
- R4: While select is high, `so_oe_o` is low. A high-to-low select transition pulses `start_o`, drives `so_oe_o` high in that same cycle, and restarts the bit and byte position.
- R5: After reset, a select that is already low is ignored, together with any clock activity, until select has been seen going from high to low.
- R6: A pause begins only when the pause pin falls while the serial clock is low. It ends only when the pin rises while the clock is low. A fall while the clock is high has no effect, and so does a rise when no pause is in progress.
- R7: During a pause, clock and data-in activity is ignored and `so_oe_o` is low. After release, reception and transmission continue from the same bit.
- R8: The pause pin has no effect while select is high.
- R9: On a low-to-high select transition that ends a transaction, `end_o` pulses. `end_bytes_o` gives the whole bytes received, modulo 2^CNT_W. `end_partial_o` is 1 if the bit position was not on a byte boundary. In that cycle `so_oe_o` is already low.
- R10: `start_o` and `end_o` are one-cycle strobes, and they are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low select pin |
| si_i | input | 1 | Serial data-in pin |
| hold_n_i | input | 1 | Active-low pause pin |
| so_o | output | 1 | Serial data-out value |
| so_oe_o | output | 1 | Output enable for data-out (low = float) |
| rx_valid_o | output | 1 | One-cycle received-byte strobe |
| rx_data_o | output | DATA_W | Received byte |
| tx_req_o | output | 1 | Transmit byte taken this cycle |
| tx_data_i | input | DATA_W | Next transmit byte, valid whenever requested |
| start_o | output | 1 | Transaction-start strobe |
| end_o | output | 1 | Transaction-end strobe |
| end_bytes_o | output | CNT_W | Whole bytes in the ended transaction |
| end_partial_o | output | 1 | Ended transaction had a trailing fragment |

## Verification
The bench builds the block with its defaults: 8-bit bytes, an 8-bit byte count and two synchroniser stages. With a serial half-period of 8 system clocks, every synchroniser and edge latency falls well inside one serial phase. That makes it possible to place pauses mid-byte, at a byte boundary, and as ignored pause glitches with the clock high, in both clock polarities. The short transfers do not reach the byte-count wrap.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  // qualified serial clock events, one system cycle wide
  typedef struct packed {
    logic rise;
    logic fall;
  } spi_fe_edge_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_s,
  input  logic         cs_n_s,
  input  logic         hold_n_s,
  output logic         active,
  output logic         paused,
  output spi_fe_edge_t edge_q,
  output logic         start_evt,
  output logic         end_evt
);
  logic sck_d, cs_d, hold_d;
  logic cs_fall, cs_rise, hold_fall, hold_rise, run;

  // previous samples; reset values match the synchroniser reset values so
  // that no edge is seen right after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
      hold_d <= 1'b1;
    end else begin
      sck_d  <= sck_s;
      cs_d   <= cs_n_s;
      hold_d <= hold_n_s;
    end
  end

  assign cs_fall   = cs_d & ~cs_n_s;
  assign cs_rise   = ~cs_d & cs_n_s;
  assign hold_fall = hold_d & ~hold_n_s;
  assign hold_rise = ~hold_d & hold_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      paused <= 1'b0;
    end else if (cs_fall) begin
      active <= 1'b1;
      paused <= 1'b0;
    end else if (cs_rise) begin
      active <= 1'b0;
      paused <= 1'b0;
    end else if (active) begin
      if (!paused && hold_fall && !sck_s)     paused <= 1'b1;
      else if (paused && hold_rise && !sck_s) paused <= 1'b0;
    end
  end

  assign run         = active & ~paused;
  assign edge_q.rise = run & ~sck_d & sck_s;
  assign edge_q.fall = run & sck_d & ~sck_s;
  assign start_evt   = cs_fall;
  assign end_evt     = cs_rise & active;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              si_s,
  input  logic              start_evt,
  input  logic              end_evt,
  output logic              at_boundary,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              end_o,
  output logic [CNT_W-1:0]  end_bytes_o,
  output logic              end_partial_o
);
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  byte_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_sh;

  assign next_sh     = {shreg[DATA_W-2:0], si_s};
  assign at_boundary = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt       <= '0;
      byte_cnt      <= '0;
      shreg         <= '0;
      rx_valid_o    <= 1'b0;
      rx_data_o     <= '0;
      end_o         <= 1'b0;
      end_bytes_o   <= '0;
      end_partial_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      end_o      <= 1'b0;
      if (start_evt) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (end_evt) begin
        end_o         <= 1'b1;
        end_bytes_o   <= byte_cnt;
        end_partial_o <= (bit_cnt != '0);
        bit_cnt       <= '0;
      end else if (rise) begin
        shreg <= next_sh;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          byte_cnt   <= byte_cnt + CNT_W'(1);
          rx_valid_o <= 1'b1;
          rx_data_o  <= next_sh;
        end else begin
          bit_cnt <= bit_cnt + BIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              start_evt,
  input  logic              at_boundary,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_req_o,
  output logic              so_o
);
  logic [DATA_W-1:0] sh;
  logic              armed;   // a rising edge has been seen since the last fall
  logic              shift_ok;
  logic              load;

  assign shift_ok = fall & armed;
  assign load     = start_evt | (shift_ok & at_boundary);
  assign tx_req_o = load;
  assign so_o     = sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      armed <= 1'b0;
    end else begin
      if (load)          sh <= tx_data_i;
      else if (shift_ok) sh <= {sh[DATA_W-2:0], 1'b0};

      if (start_evt) armed <= 1'b0;
      else if (rise) armed <= 1'b1;
      else if (fall) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_fe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_req_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              start_o,
  output logic              end_o,
  output logic [CNT_W-1:0]  end_bytes_o,
  output logic              end_partial_o
);
  localparam int NSIG = 4;
  // bit order: {pause, data-in, select, clock}; select resets low so a
  // select held low through reset never reads as a fresh falling edge
  localparam logic [NSIG-1:0] SYNC_INIT = 4'b1000;

  logic [NSIG-1:0] pins_raw, pins_s;
  logic            active, paused, start_evt, end_evt, at_boundary;
  spi_fe_edge_t    edge_q;

  assign pins_raw = {hold_n_i, si_i, cs_n_i, sck_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(SYNC_INIT[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw[g]),
      .q    (pins_s[g])
    );
  end

  spi_fe_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (pins_s[0]),
    .cs_n_s   (pins_s[1]),
    .hold_n_s (pins_s[3]),
    .active   (active),
    .paused   (paused),
    .edge_q   (edge_q),
    .start_evt(start_evt),
    .end_evt  (end_evt)
  );

  spi_fe_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise         (edge_q.rise),
    .si_s         (pins_s[2]),
    .start_evt    (start_evt),
    .end_evt      (end_evt),
    .at_boundary  (at_boundary),
    .rx_valid_o   (rx_valid_o),
    .rx_data_o    (rx_data_o),
    .end_o        (end_o),
    .end_bytes_o  (end_bytes_o),
    .end_partial_o(end_partial_o)
  );

  spi_fe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (edge_q.rise),
    .fall       (edge_q.fall),
    .start_evt  (start_evt),
    .at_boundary(at_boundary),
    .tx_data_i  (tx_data_i),
    .tx_req_o   (tx_req_o),
    .so_o       (so_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_o <= 1'b0;
    else        start_o <= start_evt;
  end

  assign so_oe_o = active & ~paused;
endmodule

// File: rtl/spi_hold_frontend_chk.sv
module spi_hold_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_i,
  input logic so_oe_o,
  input logic rx_valid_o,
  input logic tx_req_o,
  input logic start_o,
  input logic end_o
);
  // R4
  cs_high_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !so_oe_o);

  // R4
  start_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> so_oe_o);

  // R1
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R2
  tx_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  // R9
  end_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !so_oe_o);

  // R10
  start_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !end_o);

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

bind spi_hold_frontend spi_hold_frontend_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n_i    (cs_n_i),
  .so_oe_o   (so_oe_o),
  .rx_valid_o(rx_valid_o),
  .tx_req_o  (tx_req_o),
  .start_o   (start_o),
  .end_o     (end_o)
);

// File: tb/spi_hold_frontend_bench.sv
module spi_hold_frontend_bench;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int H  = 8;   // serial half-period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, rx_valid, tx_req, start, endp, end_partial;
  logic [DW-1:0] rx_data, tx_data;
  logic [CW-1:0] end_bytes;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int tx_idx = 0;
  logic tx_req_q = 1'b0;

  function automatic logic [7:0] tx_pat(int i);
    return 8'((i * 37) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] dat(int seed, int i);
    return 8'(seed * 29 + i * 71 + 3);
  endfunction

  assign tx_data = tx_pat(tx_idx);

  spi_hold_frontend u_spi_hold_frontend (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe), .rx_valid_o(rx_valid),
    .rx_data_o(rx_data), .tx_req_o(tx_req), .tx_data_i(tx_data),
    .start_o(start), .end_o(endp), .end_bytes_o(end_bytes),
    .end_partial_o(end_partial)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // command layer: advance the transmit source after each request
  always @(negedge clk) tx_req_q <= tx_req;
  always @(posedge clk) if (tx_req_q) tx_idx <= tx_idx + 1;

  // monitors
  logic [7:0] rx_got[$];
  int start_cnt = 0, end_cnt = 0, last_end_bytes = 0;
  bit last_end_partial = 1'b0;

  // behavioural reference for the output enable: pins reach the state
  // three clocks after they are driven ({pause, select, clock} history)
  logic [2:0] hist[$] = '{3'b100, 3'b100, 3'b100, 3'b100};
  bit m_act = 1'b0, m_pause = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] cur, prev;
      hist.push_back({hold_n, cs_n, sck});
      cur  = hist[hist.size() - 4];
      prev = hist[hist.size() - 5];
      if (prev[1] && !cur[1]) begin
        m_act = 1'b1; m_pause = 1'b0;
      end else if (!prev[1] && cur[1]) begin
        m_act = 1'b0; m_pause = 1'b0;
      end else if (m_act) begin
        if (!m_pause && prev[2] && !cur[2] && !cur[0])      m_pause = 1'b1;
        else if (m_pause && !prev[2] && cur[2] && !cur[0])  m_pause = 1'b0;
      end
      if (hist.size() > 6) void'(hist.pop_front());
      // R4 R6 R7 R8: enable follows select and pause rules every clock
      check(so_oe === (m_act && !m_pause), "R7", "so_oe per-clock", int'(so_oe),
            int'(m_act && !m_pause));
      if (rx_valid) rx_got.push_back(rx_data);
      if (start) start_cnt++;
      if (endp) begin
        end_cnt++;
        last_end_bytes   = int'(end_bytes);
        last_end_partial = end_partial;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int req_base = 0;

  // pause_at: bit index before which a clean pause is inserted (mode 0 only)
  // glitch_at: bit index during whose high clock phase the pause pin falls
  task automatic xfer(bit mode3, int nbits, int seed, int pause_at, int glitch_at, string req);
    int rx0, st0, en0, nfull;
    logic [7:0] sob[8];
    nfull = nbits / 8;
    rx0 = rx_got.size(); st0 = start_cnt; en0 = end_cnt;
    sck = mode3; tick(4);
    cs_n = 1'b0; tick(H);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = dat(seed, i / 8)[7 - (i % 8)];
      if (i == pause_at) begin
        hold_n = 1'b0; tick(H);
        for (int k = 0; k < 3; k++) begin
          si = ~si; sck = 1'b1; tick(H); sck = 1'b0; tick(H);
        end
        hold_n = 1'b1; tick(H);
      end
      if (i == glitch_at + 1) hold_n = 1'b1;   // rises with clock low, not paused
      if (mode3) sck = 1'b0;
      si = b;
      tick(H);
      sob[i / 8][7 - (i % 8)] = so;
      sck = 1'b1;
      if (i == glitch_at) begin
        tick(2); hold_n = 1'b0; tick(H - 2);
      end else begin
        tick(H);
      end
      if (!mode3) sck = 1'b0;
    end
    hold_n = 1'b1;
    tick(H);
    cs_n = 1'b1;
    tick(8);
    // R1 received bytes
    check(rx_got.size() - rx0 == nfull, "R1", {req, " byte strobes"}, rx_got.size() - rx0, nfull);
    for (int j = 0; j < nfull && rx0 + j < rx_got.size(); j++)
      check(rx_got[rx0 + j] == dat(seed, j), "R1", {req, " rx byte"},
            int'(rx_got[rx0 + j]), int'(dat(seed, j)));
    // R2 transmitted bytes
    for (int j = 0; j < nfull; j++)
      check(sob[j] == tx_pat(req_base + j), "R2", {req, " so byte"},
            int'(sob[j]), int'(tx_pat(req_base + j)));
    req_base += 1 + nfull - ((mode3 && (nbits % 8 == 0)) ? 1 : 0);
    check(tx_idx == req_base, "R2", {req, " tx requests"}, tx_idx, req_base);
    // R9 R10 strobes
    check(start_cnt - st0 == 1, "R10", {req, " start strobes"}, start_cnt - st0, 1);
    check(end_cnt - en0 == 1, "R10", {req, " end strobes"}, end_cnt - en0, 1);
    check(last_end_bytes == nfull, "R9", {req, " end byte count"}, last_end_bytes, nfull);
    check(last_end_partial == (nbits % 8 != 0), "R9", {req, " end partial"},
          int'(last_end_partial), int'(nbits % 8 != 0));
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    cs_n = 1'b0;              // select already low through reset
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // reset state
    check(so_oe == 1'b0 && rx_valid == 1'b0 && start == 1'b0 && endp == 1'b0,
          "R4", "reset outputs idle", int'({so_oe, rx_valid, start, endp}), 0);
    // R5: clocking with select low from reset is ignored
    for (int i = 0; i < 16; i++) begin
      si = i[0]; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
    end
    tick(H);
    check(rx_got.size() == 0, "R5", "no bytes before select edge", rx_got.size(), 0);
    check(start_cnt == 0, "R5", "no start before select edge", start_cnt, 0);
    check(tx_idx == 0, "R5", "no tx request before select edge", tx_idx, 0);
    cs_n = 1'b1; tick(8);
    check(end_cnt == 0, "R5", "no end without start", end_cnt, 0);

    xfer(1'b0, 24, 1, -1, -1, "mode0 3 bytes R1 R2");
    xfer(1'b1, 16, 2, -1, -1, "mode3 2 bytes R3");
    xfer(1'b0, 13, 3, -1, -1, "mode0 partial R9");
    xfer(1'b0, 16, 4, 5, -1, "mid-byte pause R6 R7");
    xfer(1'b0, 16, 5, 8, -1, "boundary pause R7");
    xfer(1'b0, 24, 6, -1, 10, "pause pin falls with clock high R6");

    // R8: pause pin toggled while select is high
    hold_n = 1'b0; tick(20); hold_n = 1'b1; tick(20);
    check(so_oe == 1'b0, "R8", "floating while deselected", int'(so_oe), 0);
    xfer(1'b1, 11, 7, -1, -1, "mode3 partial after deselected pause R8");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule